// File: doc/BRIEF.md
# Multi-Queue Token Fan-Out and Fan-In Bridge

This block ties one host-side valid/ready channel to a set of independent token queues. On the ingress side a single host token carries one payload slice per queue. The token is offered to every ingress queue at once, and it is accepted only when all of them can take it. On the egress side the heads of several egress queues are joined into one host token. That token is presented only when every queue has data, and it is popped from all of them in the same cycle.

The point of the block is atomicity. A token either moves into, or out of, all of its queues in one cycle, or it does not move at all. No queue can see a token twice and no queue can miss one, whatever backpressure each queue applies. The payload width of a slice and the number of queues on each side are parameters. A side with no queues is allowed, and its host handshake then never stalls. The handshake path is purely combinational, so a token crosses in the same cycle it is offered. The clock and reset ports exist only to sample the protocol checks.

Top module: `tokx_bridge`

## Requirements
- R1: `hin_ready` is 1 exactly when every ingress queue ready bit in `enq_ready` is 1.
- R2: Ingress queue i sees `enq_valid[i]`=1 only when `hin_valid`=1 and every other ingress queue is ready, so a host token enters all ingress queues in one cycle or none of them.
- R3: Ingress queue i receives host payload bits [i*SLICE_W +: SLICE_W] of `hin_data` on `enq_data` at the same bit position.
- R4: `hout_valid` is 1 exactly when every egress queue valid bit in `deq_valid` is 1.
- R5: Egress queue j sees `deq_ready[j]`=1 only when `hout_ready`=1 and every other egress queue is valid, so a token leaves all egress queues in one cycle or none of them.
- R6: Host output bits [j*SLICE_W +: SLICE_W] of `hout_data` equal `deq_data` slice j.
- R7: With zero ingress queues `hin_ready` is held at 1 and `enq_valid` at 0. With zero egress queues `hout_valid` is held at 1 and `deq_ready` at 0.
- R8: Under independent random backpressure on every queue and on the host, each host ingress token arrives exactly once and in order in every ingress queue. Each egress token is delivered to the host exactly once, with all of its slices taken from the same queue position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the protocol checks |
| rst | input | 1 | Synchronous active-high reset; masks the checks |
| hin_valid | input | 1 | Host ingress token valid |
| hin_ready | output | 1 | Host ingress token accepted by all ingress queues |
| hin_data | input | IN_VEC*SLICE_W | Host ingress payload, one slice per ingress queue |
| enq_valid | output | IN_VEC | Per-queue enqueue valid |
| enq_ready | input | IN_VEC | Per-queue enqueue ready |
| enq_data | output | IN_VEC*SLICE_W | Per-queue enqueue payload slices |
| deq_valid | input | OUT_VEC | Per-queue dequeue valid |
| deq_ready | output | OUT_VEC | Per-queue dequeue ready |
| deq_data | input | OUT_VEC*SLICE_W | Per-queue head payload slices |
| hout_valid | output | 1 | Host egress token valid |
| hout_ready | input | 1 | Host egress token taken |
| hout_data | output | OUT_VEC*SLICE_W | Host egress payload joined from all egress queues |

IN_VEC and OUT_VEC are the queue counts, or 1 when a count is zero.

## Verification
The hardest case is a cycle in which some queues on a side can move and others cannot. There a careless bridge pushes a token into a subset of queues, or pops one queue early, and the slices fall out of step later. Directed tasks apply fixed partial ready and valid masks and check the exact per-queue handshake bits. A long streaming task then drives every queue ready, every queue valid and both host handshakes from independent random draws for hundreds of tokens. Each queue is modelled as a counter of accepted tokens. Every payload slice is checked against the token number it must carry, and the counters must agree at the end.

// File: rtl/tokx_pkg.sv
package tokx_pkg;
  // Upper bound on queues per side handled by the helper below.
  localparam int unsigned CH_MAX = 16;

  // 1 when every bit of v below n is set, ignoring bit position skip.
  function automatic logic all_except(input logic [CH_MAX-1:0] v,
                                      input int unsigned n,
                                      input int unsigned skip);
    logic r;
    r = 1'b1;
    for (int unsigned k = 0; k < CH_MAX; k++) begin
      if (k < n && k != skip && !v[k]) r = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/tokx_fanout.sv
module tokx_fanout
  import tokx_pkg::*;
#(
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned VEC_W   = (NUM_CH > 0) ? NUM_CH : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     src_valid,
  output logic                     src_ready,
  input  logic [VEC_W*SLICE_W-1:0] src_data,
  output logic [VEC_W-1:0]         snk_valid,
  input  logic [VEC_W-1:0]         snk_ready,
  output logic [VEC_W*SLICE_W-1:0] snk_data
);
  generate
    if (NUM_CH == 0) begin : g_none
      // R7: nothing to feed, host never stalls
      assign src_ready = 1'b1;
      assign snk_valid = '0;
      assign snk_data  = '0;
    end else begin : g_some
      logic [CH_MAX-1:0] rdy_ext;
      assign rdy_ext   = CH_MAX'(snk_ready);
      assign src_ready = &snk_ready;                     // R1
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R2: offer only when the rest of the queues can also take it
        assign snk_valid[i] = src_valid & all_except(rdy_ext, NUM_CH, i);
        assign snk_data[i*SLICE_W +: SLICE_W] = src_data[i*SLICE_W +: SLICE_W]; // R3

        a_r2_enq_only_on_host_fire: assert property (@(posedge clk) disable iff (rst)
          (snk_valid[i] && snk_ready[i]) |-> (src_valid && src_ready));
      end

      a_r2_host_fire_reaches_all: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |-> (&(snk_valid & snk_ready)));
    end
  endgenerate
endmodule

// File: rtl/tokx_join.sv
module tokx_join
  import tokx_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned VEC_W   = (NUM_CH > 0) ? NUM_CH : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VEC_W-1:0]         src_valid,
  output logic [VEC_W-1:0]         src_ready,
  input  logic [VEC_W*SLICE_W-1:0] src_data,
  output logic                     snk_valid,
  input  logic                     snk_ready,
  output logic [VEC_W*SLICE_W-1:0] snk_data
);
  generate
    if (NUM_CH == 0) begin : g_none
      // R7: nothing to wait for, host always sees a token
      assign snk_valid = 1'b1;
      assign src_ready = '0;
      assign snk_data  = '0;
    end else begin : g_some
      logic [CH_MAX-1:0] vld_ext;
      assign vld_ext   = CH_MAX'(src_valid);
      assign snk_valid = &src_valid;                     // R4
      for (genvar j = 0; j < NUM_CH; j++) begin : g_ch
        // R5: pop only when the rest of the queues pop with it
        assign src_ready[j] = snk_ready & all_except(vld_ext, NUM_CH, j);
        assign snk_data[j*SLICE_W +: SLICE_W] = src_data[j*SLICE_W +: SLICE_W]; // R6

        a_r5_deq_only_on_host_fire: assert property (@(posedge clk) disable iff (rst)
          (src_valid[j] && src_ready[j]) |-> (snk_valid && snk_ready));
      end

      a_r5_host_fire_pops_all: assert property (@(posedge clk) disable iff (rst)
        (snk_valid && snk_ready) |-> (&(src_valid & src_ready)));
    end
  endgenerate
endmodule

// File: rtl/tokx_bridge.sv
module tokx_bridge #(
  parameter int unsigned NUM_IN  = 3,
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned IN_VEC  = (NUM_IN  > 0) ? NUM_IN  : 1,
  parameter int unsigned OUT_VEC = (NUM_OUT > 0) ? NUM_OUT : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hin_valid,
  output logic                       hin_ready,
  input  logic [IN_VEC*SLICE_W-1:0]  hin_data,
  output logic [IN_VEC-1:0]          enq_valid,
  input  logic [IN_VEC-1:0]          enq_ready,
  output logic [IN_VEC*SLICE_W-1:0]  enq_data,
  input  logic [OUT_VEC-1:0]         deq_valid,
  output logic [OUT_VEC-1:0]         deq_ready,
  input  logic [OUT_VEC*SLICE_W-1:0] deq_data,
  output logic                       hout_valid,
  input  logic                       hout_ready,
  output logic [OUT_VEC*SLICE_W-1:0] hout_data
);
  tokx_fanout #(.NUM_CH(NUM_IN), .SLICE_W(SLICE_W), .VEC_W(IN_VEC)) u_fanout (
    .clk       (clk),
    .rst       (rst),
    .src_valid (hin_valid),
    .src_ready (hin_ready),
    .src_data  (hin_data),
    .snk_valid (enq_valid),
    .snk_ready (enq_ready),
    .snk_data  (enq_data)
  );

  tokx_join #(.NUM_CH(NUM_OUT), .SLICE_W(SLICE_W), .VEC_W(OUT_VEC)) u_join (
    .clk       (clk),
    .rst       (rst),
    .src_valid (deq_valid),
    .src_ready (deq_ready),
    .src_data  (deq_data),
    .snk_valid (hout_valid),
    .snk_ready (hout_ready),
    .snk_data  (hout_data)
  );
endmodule

// File: tb/tokx_bridge_tb_top.sv
`timescale 1ns/1ps
module tokx_bridge_tb_top;
  localparam int NI = 3;
  localparam int NO = 2;
  localparam int SW = 8;
  localparam int NTOK = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              hin_valid, hin_ready;
  logic [NI*SW-1:0]  hin_data;
  logic [NI-1:0]     enq_valid, enq_ready;
  logic [NI*SW-1:0]  enq_data;
  logic [NO-1:0]     deq_valid, deq_ready;
  logic [NO*SW-1:0]  deq_data;
  logic              hout_valid, hout_ready;
  logic [NO*SW-1:0]  hout_data;

  tokx_bridge #(.NUM_IN(NI), .NUM_OUT(NO), .SLICE_W(SW)) dut_i (
    .clk(clk), .rst(rst),
    .hin_valid(hin_valid), .hin_ready(hin_ready), .hin_data(hin_data),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_data(enq_data),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_data(deq_data),
    .hout_valid(hout_valid), .hout_ready(hout_ready), .hout_data(hout_data)
  );

  // Zero-queue variant for R7
  logic          z_hin_ready, z_hout_valid;
  logic [0:0]    z_enq_valid, z_deq_ready;
  logic [SW-1:0] z_enq_data, z_hout_data;

  tokx_bridge #(.NUM_IN(0), .NUM_OUT(0), .SLICE_W(SW)) dut_zero_i (
    .clk(clk), .rst(rst),
    .hin_valid(hin_valid), .hin_ready(z_hin_ready), .hin_data(hin_data[SW-1:0]),
    .enq_valid(z_enq_valid), .enq_ready(enq_ready[0:0]), .enq_data(z_enq_data),
    .deq_valid(deq_valid[0:0]), .deq_ready(z_deq_ready), .deq_data(deq_data[SW-1:0]),
    .hout_valid(z_hout_valid), .hout_ready(hout_ready), .hout_data(z_hout_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NI*SW-1:0] in_tok(input int k);
    logic [NI*SW-1:0] r;
    for (int i = 0; i < NI; i++) r[i*SW +: SW] = SW'(k*7 + i*40 + 3);
    return r;
  endfunction

  function automatic logic [NO*SW-1:0] out_tok(input int k);
    logic [NO*SW-1:0] r;
    for (int j = 0; j < NO; j++) r[j*SW +: SW] = SW'(k*13 + j*90 + 5);
    return r;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    hin_valid = 1'b0; enq_ready = '0; deq_valid = '0; hout_ready = 1'b0;
    #1;
    check("R1 reset hin_ready", 64'(hin_ready), 64'h0);
    check("R2 reset enq_valid", 64'(enq_valid), 64'h0);
    check("R5 reset deq_ready", 64'(deq_ready), 64'h0);
  endtask

  task automatic t_route;
    @(negedge clk);
    hin_valid = 1'b1; enq_ready = 3'b111; hin_data = 24'hA1B2C3;
    #1;
    check("R1 all ready", 64'(hin_ready), 64'h1);
    check("R2 all offered", 64'(enq_valid), 64'h7);
    check("R3 slices A", 64'(enq_data), 64'hA1B2C3);
    @(negedge clk);
    hin_data = 24'h0F1E2D;
    #1;
    check("R3 slices B", 64'(enq_data), 64'h0F1E2D);
  endtask

  task automatic t_partial_in;
    @(negedge clk);
    hin_valid = 1'b1; enq_ready = 3'b101;
    #1;
    check("R1 partial ready", 64'(hin_ready), 64'h0);
    check("R2 partial offer", 64'(enq_valid), 64'h2);
    check("R2 no partial accept", 64'(enq_valid & enq_ready), 64'h0);
    @(negedge clk);
    enq_ready = 3'b011;
    #1;
    check("R2 offer to stalled queue only", 64'(enq_valid), 64'h4);
    @(negedge clk);
    hin_valid = 1'b0; enq_ready = 3'b111;
    #1;
    check("R2 no host valid", 64'(enq_valid), 64'h0);
  endtask

  task automatic t_join;
    @(negedge clk);
    deq_valid = 2'b11; deq_data = 16'h5A6B; hout_ready = 1'b1;
    #1;
    check("R4 all valid", 64'(hout_valid), 64'h1);
    check("R6 joined data", 64'(hout_data), 64'h5A6B);
    check("R5 all popped", 64'(deq_ready), 64'h3);
    @(negedge clk);
    deq_valid = 2'b01;
    #1;
    check("R4 partial valid", 64'(hout_valid), 64'h0);
    check("R5 ready to empty queue only", 64'(deq_ready), 64'h2);
    @(negedge clk);
    deq_valid = 2'b11; hout_ready = 1'b0;
    #1;
    check("R5 host stalled", 64'(deq_ready), 64'h0);
  endtask

  task automatic t_zero;
    @(negedge clk);
    hin_valid = 1'b1; enq_ready = '0; deq_valid = '0; hout_ready = 1'b1;
    #1;
    check("R7 zero ingress ready", 64'(z_hin_ready), 64'h1);
    check("R7 zero ingress valid", 64'(z_enq_valid), 64'h0);
    check("R7 zero egress valid", 64'(z_hout_valid), 64'h1);
    check("R7 zero egress ready", 64'(z_deq_ready), 64'h0);
  endtask

  task automatic t_stream;
    int sent = 0;
    int got = 0;
    int recv [NI];
    int popped [NO];
    int bad_data = 0;
    int bad_sync = 0;
    for (int i = 0; i < NI; i++) recv[i] = 0;
    for (int j = 0; j < NO; j++) popped[j] = 0;
    for (int cyc = 0; cyc < 20000 && (sent < NTOK || got < NTOK); cyc++) begin
      @(negedge clk);
      for (int i = 0; i < NI; i++) enq_ready[i] = ($urandom % 4) != 0;
      hin_valid = (sent < NTOK) && (($urandom % 3) != 0);
      hin_data = in_tok(sent);
      for (int j = 0; j < NO; j++) begin
        deq_valid[j] = (popped[j] < NTOK) && (($urandom % 3) != 0);
        deq_data[j*SW +: SW] = out_tok(popped[j])[j*SW +: SW];
      end
      hout_ready = ($urandom % 4) != 0;
      #1;
      for (int i = 0; i < NI; i++) begin
        if (enq_valid[i] && enq_ready[i]) begin
          if (enq_data[i*SW +: SW] !== in_tok(recv[i])[i*SW +: SW]) bad_data++;
          recv[i]++;
        end
      end
      if (hin_valid && hin_ready) sent++;
      for (int i = 0; i < NI; i++) if (recv[i] != sent) bad_sync++;
      for (int j = 0; j < NO; j++) if (deq_valid[j] && deq_ready[j]) popped[j]++;
      if (hout_valid && hout_ready) begin
        if (hout_data !== out_tok(got)) bad_data++;
        got++;
      end
      for (int j = 0; j < NO; j++) if (popped[j] != got) bad_sync++;
    end
    check("R8 tokens sent", 64'(sent), 64'(NTOK));
    for (int i = 0; i < NI; i++) check("R8 ingress queue count", 64'(recv[i]), 64'(NTOK));
    check("R8 tokens delivered", 64'(got), 64'(NTOK));
    for (int j = 0; j < NO; j++) check("R8 egress queue count", 64'(popped[j]), 64'(NTOK));
    check("R8 payload order", 64'(bad_data), 64'h0);
    check("R8 lockstep", 64'(bad_sync), 64'h0);
  endtask

  initial begin
    hin_valid = 1'b0; hin_data = '0; enq_ready = '0;
    deq_valid = '0; deq_data = '0; hout_ready = 1'b0;
    repeat (2) @(posedge clk);
    t_reset;
    @(negedge clk);
    rst = 1'b0;
    t_route;
    t_partial_in;
    t_join;
    t_zero;
    t_stream;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule